// File: doc/BRIEF.md
# Frame-Difference Correlated Double Sampler

This block removes slowly varying offsets from a pixel sensor's digitised output. Pixels of a square matrix arrive one per clock, or with idle gaps, in a fixed raster order. For each sample, the block reads back the value that the same pixel had one frame earlier from an on-chip frame store. It outputs the signed change and writes the new sample into the same location. A change larger than a programmable level marks the pixel as a hit. A later stage can then keep only hit pixels and their neighbours.

Each output carries the pixel's row and column, which the block takes from its own scan counters. The first frame after reset only fills the store and produces no output. A frame-start marker realigns the scan counters. If the marker arrives at any position other than the origin, a sticky error flag is set.

Top module: `cds_frame_diff`

## Requirements
- R1: For every emitted pixel, `out_diff` equals the pixel's current sample minus the sample that the same pixel had in the frame before. It is signed and one bit wider than a sample, so it ranges from -(2^SAMPLE_W - 1) to +(2^SAMPLE_W - 1).
- R2: `out_hit` is 1 exactly when `out_valid` is 1 and `out_diff` is strictly greater than the signed `hit_level`. A difference equal to the level is not a hit.
- R3: A sample accepted on a rising edge appears on the outputs after exactly three rising edges. One sample can be accepted on every clock, and idle cycles between samples do not change this latency.
- R4: After reset, no output is marked valid for any sample until one sample has been accepted at the last scan position (row DIM-1, column DIM-1). Every later sample is emitted.
- R5: The scan order is column first. `out_col` counts from 0 to DIM-1 and then wraps to 0, and `out_row` advances by one at each column wrap. After the last pixel, the scan returns to row 0, column 0 without needing a marker.
- R6: A sample with `in_sof` = 1 is always treated as row 0, column 0. If the scan counters were already at the origin, the marker has no other effect. Otherwise `sof_err` becomes 1 and stays 1 until reset.
- R7: While reset is high and on the first cycle after it, `out_valid`, `out_hit` and `sof_err` are 0, and the scan restarts at the origin.
- R8: The frame store is rewritten with every accepted sample. The difference in frame n+1 is therefore taken against frame n, not against any older frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is presented this cycle |
| in_sof | input | 1 | The presented sample is the first of a frame |
| in_sample | input | SAMPLE_W | Digitised pixel value, unsigned |
| hit_level | input | SAMPLE_W+1 | Signed hit threshold, nominally 1900 |
| out_valid | output | 1 | Output fields hold a processed pixel |
| out_row | output | log2(DIM) | Row of the emitted pixel |
| out_col | output | log2(DIM) | Column of the emitted pixel |
| out_diff | output | SAMPLE_W+1 | Signed frame-to-frame difference |
| out_hit | output | 1 | Difference exceeds the hit level |
| sof_err | output | 1 | Sticky flag for a misplaced frame-start marker |

## Verification
The bench builds the block with DIM = 4 and SAMPLE_W = 12. A frame is then only 16 samples long, so the bench can reach the priming boundary, the column and row wraps, a mid-frame resynchronisation and a second, unprimed fill after a mid-run reset within a few hundred cycles. The 12-bit samples keep the nominal 1900 threshold meaningful. They also let the table test the full-scale differences of +4095 and -4095, and values one unit on either side of the threshold.

// File: rtl/cds_pkg.sv
package cds_pkg;

    // Default geometry and sample width. Production uses a 256-pixel edge.
    localparam int unsigned DEF_DIM      = 32;
    localparam int unsigned DEF_SAMPLE_W = 12;

    // Whether the frame store already holds a full frame.
    typedef enum logic {
        PH_FILL = 1'b0,
        PH_LIVE = 1'b1
    } phase_e;

    // True when the edge length is a power of two and at least 2.
    function automatic bit dim_ok(input int unsigned d);
        return (d >= 2) && ((d & (d - 1)) == 0);
    endfunction

endpackage

// File: rtl/cds_scan_ctrl.sv
module cds_scan_ctrl
    import cds_pkg::*;
#(
    parameter int unsigned DIM = DEF_DIM,
    localparam int unsigned CW = $clog2(DIM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sof,
    output logic [CW-1:0] row_o,
    output logic [CW-1:0] col_o,
    output logic          live_o,
    output logic          sof_err_o
);

    localparam logic [CW-1:0] LAST = CW'(DIM - 1);

    logic [CW-1:0] row_q, col_q;
    phase_e        ph_q;
    logic          err_q;
    logic          at_origin, at_last, col_end;

    // A frame-start marker forces the current sample to the origin.
    always_comb begin
        at_origin = (row_q == '0) && (col_q == '0);
        row_o     = in_sof ? '0 : row_q;
        col_o     = in_sof ? '0 : col_q;
        col_end   = (col_o == LAST);
        at_last   = col_end && (row_o == LAST);
        live_o    = (ph_q == PH_LIVE);
        sof_err_o = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
            ph_q  <= PH_FILL;
            err_q <= 1'b0;
        end else if (in_valid) begin
            if (at_last) begin
                row_q <= '0;
                col_q <= '0;
                ph_q  <= PH_LIVE;
            end else if (col_end) begin
                col_q <= '0;
                row_q <= row_o + CW'(1);
            end else begin
                row_q <= row_o;
                col_q <= col_o + CW'(1);
            end
            if (in_sof && !at_origin) begin
                err_q <= 1'b1;
            end
        end
    end

    assert_col_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sof && col_q == LAST) |=> (col_q == '0));

    assert_err_on_misplaced_sof_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof && !at_origin) |=> err_q);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    assert_fill_until_last_R4: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_FILL && !(in_valid && at_last)) |=> (ph_q == PH_FILL));

endmodule

// File: rtl/cds_frame_store.sv
module cds_frame_store #(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 12,
    localparam int unsigned DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Read and write share one address. The read returns the old content.
    always_ff @(posedge clk) begin
        rdata <= mem[addr];
        if (we) begin
            mem[addr] <= wdata;
        end
    end

endmodule

// File: rtl/cds_diff_stage.sv
module cds_diff_stage #(
    parameter int unsigned SW = 12,
    parameter int unsigned CW = 5,
    localparam int unsigned DW = SW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 s1_vld,
    input  logic [CW-1:0]        s1_row,
    input  logic [CW-1:0]        s1_col,
    input  logic [SW-1:0]        s1_smp,
    input  logic [SW-1:0]        s1_prev,
    input  logic signed [DW-1:0] level,
    output logic                 o_vld,
    output logic [CW-1:0]        o_row,
    output logic [CW-1:0]        o_col,
    output logic signed [DW-1:0] o_diff,
    output logic                 o_hit
);

    typedef struct packed {
        logic                 vld;
        logic [CW-1:0]        row;
        logic [CW-1:0]        col;
        logic signed [DW-1:0] diff;
    } s2_t;

    s2_t s2_q, s2_d;

    always_comb begin
        s2_d.vld  = s1_vld;
        s2_d.row  = s1_row;
        s2_d.col  = s1_col;
        s2_d.diff = $signed({1'b0, s1_smp}) - $signed({1'b0, s1_prev});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q <= s2_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_vld  <= 1'b0;
            o_row  <= '0;
            o_col  <= '0;
            o_diff <= '0;
            o_hit  <= 1'b0;
        end else begin
            o_vld  <= s2_q.vld;
            o_row  <= s2_q.row;
            o_col  <= s2_q.col;
            o_diff <= s2_q.diff;
            o_hit  <= s2_q.vld && (s2_q.diff > level);
        end
    end

    assert_hit_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
        o_hit |-> o_vld);

    assert_valid_from_stage2_R3: assert property (@(posedge clk) disable iff (rst)
        o_vld |-> $past(s1_vld, 2));

endmodule

// File: rtl/cds_frame_diff.sv
module cds_frame_diff
    import cds_pkg::*;
#(
    parameter int unsigned DIM      = DEF_DIM,
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    localparam int unsigned CW      = $clog2(DIM),
    localparam int unsigned AW      = 2 * CW,
    localparam int unsigned DIFF_W  = SAMPLE_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic [SAMPLE_W-1:0]      in_sample,
    input  logic signed [DIFF_W-1:0] hit_level,
    output logic                     out_valid,
    output logic [CW-1:0]            out_row,
    output logic [CW-1:0]            out_col,
    output logic signed [DIFF_W-1:0] out_diff,
    output logic                     out_hit,
    output logic                     sof_err
);

    typedef struct packed {
        logic                vld;
        logic [CW-1:0]       row;
        logic [CW-1:0]       col;
        logic [SAMPLE_W-1:0] smp;
    } s1_t;

    logic [CW-1:0]       pos_row, pos_col;
    logic                live;
    logic [SAMPLE_W-1:0] prev;
    s1_t                 s1_q;

    // Geometry guard: a raster address must be a plain concatenation.
    if (!dim_ok(DIM)) begin : g_bad_dim
        initial $error("DIM must be a power of two and at least 2");
    end

    cds_scan_ctrl #(.DIM(DIM)) u_scan (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .row_o     (pos_row),
        .col_o     (pos_col),
        .live_o    (live),
        .sof_err_o (sof_err)
    );

    cds_frame_store #(.AW(AW), .DW(SAMPLE_W)) u_store (
        .clk   (clk),
        .we    (in_valid),
        .addr  ({pos_row, pos_col}),
        .wdata (in_sample),
        .rdata (prev)
    );

    // Stage 1: keep the sample alongside the store read issued this edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld <= in_valid && live;
            s1_q.row <= pos_row;
            s1_q.col <= pos_col;
            s1_q.smp <= in_sample;
        end
    end

    cds_diff_stage #(.SW(SAMPLE_W), .CW(CW)) u_diff (
        .clk     (clk),
        .rst     (rst),
        .s1_vld  (s1_q.vld),
        .s1_row  (s1_q.row),
        .s1_col  (s1_q.col),
        .s1_smp  (s1_q.smp),
        .s1_prev (prev),
        .level   (hit_level),
        .o_vld   (out_valid),
        .o_row   (out_row),
        .o_col   (out_col),
        .o_diff  (out_diff),
        .o_hit   (out_hit)
    );

    assert_latency_three_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

    assert_no_output_unprimed_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !live) |=> !s1_q.vld);

endmodule

// File: tb/sim_cds_frame_diff.sv
module sim_cds_frame_diff;

    localparam int DIM = 4;
    localparam int SW  = 12;
    localparam int CW  = 2;
    localparam int NPX = DIM * DIM;

    typedef struct packed {
        logic [SW-1:0]        prev;
        logic [SW-1:0]        cur;
        logic signed [SW:0]   diff;
        logic                 hit;
    } vec_t;

    // Threshold 1900: values around the boundary and at full scale.
    localparam vec_t TAB [NPX] = '{
        '{12'd100,  12'd100,  13'sd0,     1'b0},
        '{12'd0,    12'd1900, 13'sd1900,  1'b0},
        '{12'd0,    12'd1901, 13'sd1901,  1'b1},
        '{12'd4095, 12'd0,    -13'sd4095, 1'b0},
        '{12'd0,    12'd4095, 13'sd4095,  1'b1},
        '{12'd2000, 12'd100,  -13'sd1900, 1'b0},
        '{12'd500,  12'd2401, 13'sd1901,  1'b1},
        '{12'd500,  12'd2400, 13'sd1900,  1'b0},
        '{12'd1234, 12'd1235, 13'sd1,     1'b0},
        '{12'd3000, 12'd2999, -13'sd1,    1'b0},
        '{12'd10,   12'd3000, 13'sd2990,  1'b1},
        '{12'd4000, 12'd4000, 13'sd0,     1'b0},
        '{12'd7,    12'd1908, 13'sd1901,  1'b1},
        '{12'd1,    12'd0,    -13'sd1,    1'b0},
        '{12'd2048, 12'd4095, 13'sd2047,  1'b1},
        '{12'd0,    12'd0,    13'sd0,     1'b0}
    };

    typedef struct {
        int cyc;
        int row;
        int col;
        int diff;
        bit hit;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic                 in_sof = 1'b0;
    logic [SW-1:0]        in_sample = '0;
    logic signed [SW:0]   hit_level = 13'sd1900;
    logic                 out_valid;
    logic [CW-1:0]        out_row, out_col;
    logic signed [SW:0]   out_diff;
    logic                 out_hit;
    logic                 sof_err;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   done = 1'b0;
    exp_t expq[$];

    // Bench model of the scan position, frame contents and priming.
    int   bpos = 0;
    bit   bprimed = 1'b0;
    int   thr = 1900;
    int   mprev [NPX];

    cds_frame_diff #(.DIM(DIM), .SAMPLE_W(SW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_sample (in_sample),
        .hit_level (hit_level),
        .out_valid (out_valid),
        .out_row   (out_row),
        .out_col   (out_col),
        .out_diff  (out_diff),
        .out_hit   (out_hit),
        .sof_err   (sof_err)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Output monitor, sampling away from the rising edge.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R4 unexpected output", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(int'(out_row) == e.row, "R5 row", int'(out_row), e.row);
                check(int'(out_col) == e.col, "R5 col", int'(out_col), e.col);
                check(int'(out_diff) == e.diff, "R1 diff", int'(out_diff), e.diff);
                check(out_hit == e.hit, "R2 hit", int'(out_hit), int'(e.hit));
                check(cyc == e.cyc, "R3 latency", cyc, e.cyc);
            end
        end
    end

    // Watchdog: counts as a failed check and still reaches the summary.
    always @(posedge clk) begin
        if (cyc > 20000) begin
            check(1'b0, "watchdog", cyc, 20000);
            report();
        end
    end

    task automatic send(input bit sof, input int smp, input bit use_tab,
                        input int tdiff, input bit thit);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sof    = sof;
        in_sample = SW'(smp);
        if (sof) bpos = 0;
        if (bprimed) begin
            exp_t e;
            e.cyc  = cyc + 3;
            e.row  = bpos / DIM;
            e.col  = bpos % DIM;
            e.diff = use_tab ? tdiff : (smp - mprev[bpos]);
            e.hit  = use_tab ? thit : ((smp - mprev[bpos]) > thr);
            expq.push_back(e);
        end
        mprev[bpos] = smp;
        if (bpos == NPX - 1) begin
            bprimed = 1'b1;
            bpos = 0;
        end else begin
            bpos++;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sof   = 1'b0;
        end
    endtask

    task automatic drain(input string req);
        idle(5);
        check(expq.size() == 0, req, expq.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < NPX; i++) mprev[i] = 0;
        idle(3);
        check(out_valid == 1'b0, "R7 out_valid in reset", int'(out_valid), 0);
        check(sof_err == 1'b0, "R7 sof_err in reset", int'(sof_err), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_hit == 1'b0, "R7 outputs after reset",
              int'(out_valid), 0);

        // Frame 0 fills the store only (R4), marker at the origin (R6).
        for (int i = 0; i < NPX; i++) send(i == 0, int'(TAB[i].prev), 1'b0, 0, 1'b0);
        idle(4);
        check(sof_err == 1'b0, "R6 marker at origin", int'(sof_err), 0);
        check(expq.size() == 0, "R4 first frame silent", expq.size(), 0);

        // Table walk: frame 1 against frame 0 (R1, R2, R3, R5).
        for (int i = 0; i < NPX; i++)
            send(i == 0, int'(TAB[i].cur), 1'b1, int'(TAB[i].diff), TAB[i].hit);
        drain("R3 all table outputs emitted");

        // Frame 2 without a marker, with gaps: wrap of the scan (R5) and
        // differences against frame 1 rather than frame 0 (R8).
        for (int i = 0; i < NPX; i++) begin
            send(1'b0, (i * 251) % 4096, 1'b0, 0, 1'b0);
            if (i % 3 == 2) idle(1);
        end
        drain("R8 frame 2 outputs emitted");

        // Zero threshold: any positive change is a hit (R2).
        thr = 0;
        hit_level = 13'sd0;
        for (int i = 0; i < NPX; i++) send(i == 0, mprev[i] + ((i % 2 == 0) ? 1 : 0), 1'b0, 0, 1'b0);
        drain("R2 zero threshold frame emitted");
        thr = 1900;
        hit_level = 13'sd1900;

        // Misplaced marker: error set, sticky, scan restarts (R6).
        for (int i = 0; i < 5; i++) send(1'b0, 1000 + i, 1'b0, 0, 1'b0);
        send(1'b1, 3500, 1'b0, 0, 1'b0);
        idle(1);
        check(sof_err == 1'b1, "R6 misplaced marker flagged", int'(sof_err), 1);
        for (int i = 1; i < NPX; i++) send(1'b0, 50 * i, 1'b0, 0, 1'b0);
        send(1'b1, 7, 1'b0, 0, 1'b0);
        drain("R6 resynced frame emitted");
        check(sof_err == 1'b1, "R6 error sticky", int'(sof_err), 1);

        // Mid-run reset: error cleared, store refill is silent (R7, R4).
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        bpos = 0;
        bprimed = 1'b0;
        @(negedge clk);
        check(sof_err == 1'b0, "R7 error cleared by reset", int'(sof_err), 0);
        for (int i = 0; i < NPX; i++) send(i == 0, 4095 - 100 * i, 1'b0, 0, 1'b0);
        idle(4);
        check(expq.size() == 0, "R4 refill after reset silent", expq.size(), 0);
        for (int i = 0; i < NPX; i++) send(1'b0, 4095 - 99 * i, 1'b0, 0, 1'b0);
        drain("R4 primed again after full frame");

        report();
    end

endmodule